// File: doc/BRIEF.md
# Linked-Descriptor Chain Sequencer

This block is the control engine of a memory-to-memory accelerator. Software places a chain of descriptors in memory, each one 32-byte aligned, each one linked to the next through a pointer in its first word. Software writes the address of the first descriptor into the chain-pointer register and then writes 1 to the run bit of the control register. From then on the engine reads each descriptor one word at a time over a simple read port and presents the source addresses, destination, byte count and control word to a datapath. It waits for the datapath to report that the descriptor is finished and then follows the link. A link of zero ends the chain.

Completion and faults are reported in a status register whose event bits are cleared by writing ones. The interrupt line is high whenever any event bit is set. A descriptor produces an event only when bit 0 of its own control word is set. Such an event is recorded as a chain-end event when it is the last descriptor, and as a per-descriptor event otherwise. An error response on a descriptor read, or an error reported by the datapath, records a bus-fault event and halts the chain.

Top module: `dchain_engine`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the chain-pointer register reads 0, and `irq`, `mem_req` and `xfer_valid` are low.
- R2: The low five bits of the chain pointer are always zero. This holds for pointers written by software (register address 2) and for links fetched from memory. A link whose upper bits are all zero ends the chain, whatever its low five bits hold.
- R3: Writing 1 to bit 0 of the control register (address 0) while idle, with a nonzero chain pointer, sets the active flag. The active flag is status bit 0, and bit 0 of the control register reads the same flag. The engine then reads the descriptor words at pointer+4*k, for k = 0 to NSRC+3, in ascending order. Word 0 is the link, words 1 to NSRC are the sources, and the following words are the destination, the byte count and the control word.
- R4: Each descriptor's fields are held on the `xfer_*` outputs with `xfer_valid` high until `xfer_done`. Every descriptor of a chain is presented exactly once, in link order.
- R5: When a descriptor whose link is zero completes, the active flag clears and both the control register and the chain pointer read 0.
- R6: A completed descriptor whose control word has bit 0 set sets status bit 1 (chain-end) if its link is zero, and status bit 2 (per-descriptor) otherwise. With bit 0 clear, neither bit is set.
- R7: An error on a descriptor read (`mem_err` with `mem_ack`), or `xfer_err` with `xfer_done`, sets status bit 3 (bus fault). It also clears the active flag, produces no event for that descriptor, and stops all further reads.
- R8: Writing to the status register (address 1) clears each of bits 3..1 that is written as 1, and leaves the bits written as 0 unchanged. An event arriving in the same cycle takes priority over the clear.
- R9: `irq` is high exactly when at least one of status bits 3..1 is set.
- R10: Writing 0 to bit 0 of the control register stops the engine at the next clock edge. `mem_req` and `xfer_valid` drop, the active flag clears, and no event bit is set.
- R11: While the engine is active, writes to the chain pointer and further writes of 1 to the control register have no effect.
- R12: Writing 1 to the control register while the chain pointer is zero starts nothing. No read is issued and the active flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 chain pointer |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | W | Byte address of the descriptor word |
| mem_ack | input | 1 | Read response valid in this cycle |
| mem_err | input | 1 | Read response carries an error |
| mem_rdata | input | W | Read response data |
| xfer_valid | output | 1 | Descriptor fields valid for the datapath |
| xfer_src | output | NSRC*W | Source addresses, source 0 in the low bits |
| xfer_dst | output | W | Destination address |
| xfer_len | output | W | Byte count |
| xfer_ctrl | output | W | Descriptor control word |
| xfer_done | input | 1 | Datapath finished the current descriptor |
| xfer_err | input | 1 | Datapath fault, qualified by xfer_done |
| irq | output | 1 | Interrupt request |

## Verification
A wrong word counter or a wrong base address shows up as fields on the `xfer_*` outputs that do not match the descriptor stored in memory. That mismatch is visible at the first `xfer_valid` after the fault. A stale or unmasked link pointer shows as a descriptor skipped, repeated or taken out of order. It is caught when the datapath log is compared at the end of the chain, and sooner by reading back the chain-pointer register during a transfer. Faulty event routing between the sequencer and the status bits shows on `irq` and on a status read the cycle after the completing edge.

// File: rtl/dce_pkg.sv
`timescale 1ns/1ps
package dce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2
    } seq_state_e;

    localparam int ALIGN_BITS = 5;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_NDA  = 2'd2;

    localparam int CTL_IE_BIT = 0;

    typedef struct packed {
        logic ma;
        logic eot;
        logic eoc;
    } stat_t;
endpackage

// File: rtl/dce_seq.sv
`timescale 1ns/1ps
module dce_seq
    import dce_pkg::*;
#(
    parameter int W    = 32,
    parameter int NSRC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  nda_wr_i,
    input  logic [W-1:ALIGN_BITS] nda_wdata_i,
    output logic                  busy_o,
    output logic [W-1:0]          nda_o,
    output logic                  mem_req_o,
    output logic [W-1:0]          mem_addr_o,
    input  logic                  mem_ack_i,
    input  logic                  mem_err_i,
    input  logic [W-1:0]          mem_rdata_i,
    output logic                  xfer_valid_o,
    output logic [NSRC*W-1:0]     xfer_src_o,
    output logic [W-1:0]          xfer_dst_o,
    output logic [W-1:0]          xfer_len_o,
    output logic [W-1:0]          xfer_ctrl_o,
    input  logic                  xfer_done_i,
    input  logic                  xfer_err_i,
    output logic                  ev_eoc_o,
    output logic                  ev_eot_o,
    output logic                  ev_ma_o
);
    localparam int NWORDS = NSRC + 4;
    localparam int NFLD   = NWORDS - 1;
    localparam int IDXW   = $clog2(NWORDS);
    localparam int F_DST  = NSRC;
    localparam int F_LEN  = NSRC + 1;
    localparam int F_CTL  = NSRC + 2;
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NWORDS - 1);

    typedef struct packed {
        seq_state_e              st;
        logic [W-1:0]            cur;
        logic [W-1:0]            nda;
        logic [IDXW-1:0]         idx;
        logic [NFLD-1:0][W-1:0]  fld;
    } seq_t;

    seq_t q, d;
    logic eoc_c, eot_c, ma_c;

    function automatic logic [W-1:0] align_ptr(input logic [W-1:0] v);
        return {v[W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    always_comb begin
        d     = q;
        eoc_c = 1'b0;
        eot_c = 1'b0;
        ma_c  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (nda_wr_i) begin
                    d.nda = {nda_wdata_i, {ALIGN_BITS{1'b0}}};
                end
                if (start_i && (q.nda != '0)) begin
                    d.st  = ST_FETCH;
                    d.cur = q.nda;
                    d.idx = '0;
                end
            end
            ST_FETCH: begin
                if (mem_ack_i) begin
                    if (mem_err_i) begin
                        ma_c = 1'b1;
                        d.st = ST_IDLE;
                    end else begin
                        if (q.idx == '0) begin
                            d.nda = align_ptr(mem_rdata_i);
                        end
                        for (int k = 0; k < NFLD; k++) begin
                            if (q.idx == IDXW'(k + 1)) begin
                                d.fld[k] = mem_rdata_i;
                            end
                        end
                        if (q.idx == IDX_LAST) begin
                            d.st = ST_XFER;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
            end
            ST_XFER: begin
                if (xfer_done_i) begin
                    if (xfer_err_i) begin
                        ma_c = 1'b1;
                        d.st = ST_IDLE;
                    end else begin
                        if (q.fld[F_CTL][CTL_IE_BIT]) begin
                            eoc_c = (q.nda == '0);
                            eot_c = (q.nda != '0);
                        end
                        if (q.nda == '0) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_FETCH;
                            d.cur = q.nda;
                            d.idx = '0;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (stop_i) begin
            d.st  = ST_IDLE;
            eoc_c = 1'b0;
            eot_c = 1'b0;
            ma_c  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = (q.st != ST_IDLE);
    assign nda_o        = q.nda;
    assign mem_req_o    = (q.st == ST_FETCH);
    assign mem_addr_o   = q.cur + {{(W-IDXW-2){1'b0}}, q.idx, 2'b00};
    assign xfer_valid_o = (q.st == ST_XFER);
    assign xfer_dst_o   = q.fld[F_DST];
    assign xfer_len_o   = q.fld[F_LEN];
    assign xfer_ctrl_o  = q.fld[F_CTL];
    assign ev_eoc_o     = eoc_c;
    assign ev_eot_o     = eot_c;
    assign ev_ma_o      = ma_c;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign xfer_src_o[s*W +: W] = q.fld[s];
    end

    // R10: a stop request empties the engine on the next edge
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !busy_o);

    // R4: fields stay put until the datapath finishes
    a_r4_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_done_i && !stop_i) |=>
            (xfer_valid_o && $stable(xfer_dst_o) && $stable(xfer_ctrl_o)));

    // R7: a faulted read ends all fetching
    a_r7_fetch_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && mem_err_i) |=> (!mem_req_o && !xfer_valid_o));

    // R2: the held chain pointer never has low bits set
    a_r2_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        nda_o[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/dce_status.sv
`timescale 1ns/1ps
module dce_status
    import dce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       ev_eoc_i,
    input  logic       ev_eot_i,
    input  logic       ev_ma_i,
    input  logic       clr_we_i,
    input  logic [2:0] clr_mask_i,
    output logic [3:0] stat_o,
    output logic       irq_o
);
    stat_t q, d;

    always_comb begin
        d = q;
        if (clr_we_i) begin
            d = stat_t'(q & ~clr_mask_i);
        end
        if (ev_eoc_i) d.eoc = 1'b1;
        if (ev_eot_i) d.eot = 1'b1;
        if (ev_ma_i)  d.ma  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat_o = {q.ma, q.eot, q.eoc, busy_i};
    assign irq_o  = q.ma | q.eot | q.eoc;

    // R8: a written one clears a bit when no event competes
    a_r8_w1c_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_mask_i[0] && !ev_eoc_i) |=> !stat_o[1]);

    // R8: an event wins over a simultaneous clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ma_i |=> stat_o[3]);

    // R9: the interrupt only rises after an event
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ev_eoc_i | ev_eot_i | ev_ma_i));
endmodule

// File: rtl/dchain_engine.sv
`timescale 1ns/1ps
module dchain_engine
    import dce_pkg::*;
#(
    parameter int W    = 32,
    parameter int NSRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              mem_req,
    output logic [W-1:0]      mem_addr,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [W-1:0]      mem_rdata,
    output logic              xfer_valid,
    output logic [NSRC*W-1:0] xfer_src,
    output logic [W-1:0]      xfer_dst,
    output logic [W-1:0]      xfer_len,
    output logic [W-1:0]      xfer_ctrl,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              irq
);
    logic         wr_ctrl, start_c, stop_c, nda_wr_c, clr_we_c;
    logic         busy;
    logic [W-1:0] nda;
    logic [3:0]   stat;
    logic         ev_eoc, ev_eot, ev_ma;
    logic         unused_wbit;

    assign wr_ctrl     = reg_we && (reg_addr == REG_CTRL);
    assign start_c     = wr_ctrl && reg_wdata[0];
    assign stop_c      = wr_ctrl && !reg_wdata[0];
    assign nda_wr_c    = reg_we && (reg_addr == REG_NDA);
    assign clr_we_c    = reg_we && (reg_addr == REG_STAT);
    assign unused_wbit = reg_wdata[4];

    dce_seq #(.W(W), .NSRC(NSRC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_c),
        .stop_i       (stop_c),
        .nda_wr_i     (nda_wr_c),
        .nda_wdata_i  (reg_wdata[W-1:ALIGN_BITS]),
        .busy_o       (busy),
        .nda_o        (nda),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_ack_i    (mem_ack),
        .mem_err_i    (mem_err),
        .mem_rdata_i  (mem_rdata),
        .xfer_valid_o (xfer_valid),
        .xfer_src_o   (xfer_src),
        .xfer_dst_o   (xfer_dst),
        .xfer_len_o   (xfer_len),
        .xfer_ctrl_o  (xfer_ctrl),
        .xfer_done_i  (xfer_done),
        .xfer_err_i   (xfer_err),
        .ev_eoc_o     (ev_eoc),
        .ev_eot_o     (ev_eot),
        .ev_ma_o      (ev_ma)
    );

    dce_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy),
        .ev_eoc_i   (ev_eoc),
        .ev_eot_i   (ev_eot),
        .ev_ma_i    (ev_ma),
        .clr_we_i   (clr_we_c),
        .clr_mask_i (reg_wdata[3:1]),
        .stat_o     (stat),
        .irq_o      (irq)
    );

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = {{(W-1){1'b0}}, busy};
            REG_STAT: reg_rdata = {{(W-4){1'b0}}, stat};
            REG_NDA:  reg_rdata = nda;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: a chain-pointer read never shows low bits
    a_r2_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_NDA) |-> (reg_rdata[ALIGN_BITS-1:0] == '0));

    // R3: descriptor reads are word addressed
    a_r3_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R12: a start with an empty pointer issues no read
    a_r12_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && !busy && (nda == '0)) |=> !mem_req);
endmodule

// File: tb/sim_dchain_engine.sv
`timescale 1ns/1ps
module sim_dchain_engine;
    localparam int W = 32;
    localparam int NSRC = 2;

    typedef struct packed {
        int       n;
        int       slot;
        int       stride;
        logic [7:0] ie;
        logic     junk;
        logic     exp_eoc;
        logic     exp_eot;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{n:1, slot:2,  stride:1,  ie:8'h01, junk:1'b0, exp_eoc:1'b1, exp_eot:1'b0},
        '{n:1, slot:3,  stride:1,  ie:8'h00, junk:1'b0, exp_eoc:1'b0, exp_eot:1'b0},
        '{n:3, slot:4,  stride:1,  ie:8'h02, junk:1'b0, exp_eoc:1'b0, exp_eot:1'b1},
        '{n:4, slot:20, stride:-5, ie:8'h09, junk:1'b1, exp_eoc:1'b1, exp_eot:1'b1},
        '{n:5, slot:21, stride:2,  ie:8'h00, junk:1'b1, exp_eoc:1'b0, exp_eot:1'b0},
        '{n:2, slot:7,  stride:9,  ie:8'h03, junk:1'b0, exp_eoc:1'b1, exp_eot:1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic mem_req, mem_ack, mem_err;
    logic [W-1:0] mem_addr, mem_rdata;
    logic xfer_valid;
    logic [NSRC*W-1:0] xfer_src;
    logic [W-1:0] xfer_dst, xfer_len, xfer_ctrl;
    logic xfer_done = 1'b0;
    logic xfer_err = 1'b0;
    logic irq;

    logic [31:0] mem [256];
    logic        err_fetch_on = 1'b0;
    logic [31:0] err_addr = '0;
    int          err_xfer_at = -1;
    int          resp_delay = 2;
    int          resp_cnt = 0;
    int          log_n = 0;
    logic [31:0] log_s0 [16], log_s1 [16], log_dst [16], log_len [16], log_ctl [16];
    logic [31:0] ex_s0 [16], ex_s1 [16], ex_dst [16], ex_len [16], ex_ctl [16], ex_addr [16];

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dchain_engine #(.W(W), .NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata),
        .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_ctrl(xfer_ctrl), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .irq(irq)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_err   = mem_req && err_fetch_on && (mem_addr == err_addr);

    always @(negedge clk) begin
        if (xfer_done) begin
            xfer_done = 1'b0;
            xfer_err  = 1'b0;
        end else if (xfer_valid) begin
            if (resp_cnt >= resp_delay) begin
                xfer_done = 1'b1;
                xfer_err  = (log_n == err_xfer_at);
                log_s0[log_n]  = xfer_src[31:0];
                log_s1[log_n]  = xfer_src[63:32];
                log_dst[log_n] = xfer_dst;
                log_len[log_n] = xfer_len;
                log_ctl[log_n] = xfer_ctrl;
                log_n++;
                resp_cnt = 0;
            end else begin
                resp_cnt++;
            end
        end else begin
            resp_cnt = 0;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            rd(2'd0, v);
            if (v[0] == 1'b0) return;
        end
    endtask

    task automatic wait_valid();
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            #1;
            if (xfer_valid) return;
        end
    endtask

    // builds a chain; desc i sits at slot+i*stride (32-byte slots)
    task automatic build(input int tag, input int n, input int slot, input int stride,
                         input logic [7:0] ie, input logic junk);
        for (int i = 0; i < n; i++) begin
            int s;
            logic [31:0] a, nx;
            s = slot + i * stride;
            a = 32'(s * 32);
            nx = (i == n - 1) ? 32'h0 : 32'((slot + (i + 1) * stride) * 32);
            if (junk) nx = nx | 32'h1B;
            ex_addr[i] = a;
            ex_s0[i]  = 32'hA000_0000 + 32'(tag << 12) + 32'(i);
            ex_s1[i]  = 32'hA000_0100 + 32'(tag << 12) + 32'(i);
            ex_dst[i] = 32'hB000_0000 + 32'(tag << 12) + 32'(i);
            ex_len[i] = 32'(64 * (i + 1));
            ex_ctl[i] = 32'(tag << 8) | 32'(i << 4) | {31'b0, ie[i]};
            mem[s*8 + 0] = nx;
            mem[s*8 + 1] = ex_s0[i];
            mem[s*8 + 2] = ex_s1[i];
            mem[s*8 + 3] = ex_dst[i];
            mem[s*8 + 4] = ex_len[i];
            mem[s*8 + 5] = ex_ctl[i];
        end
        log_n = 0;
    endtask

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 256; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 chain ptr", v, 0);
        chk("R1 irq/req/valid", {29'b0, irq, mem_req, xfer_valid}, 0);

        // R12 start with empty pointer
        wr(2'd0, 32'h1);
        rd(2'd0, v); chk("R12 no start", v, 0);
        chk("R12 no read", {31'b0, mem_req}, 0);

        // R2 low bits masked on write
        wr(2'd2, 32'h0000_03FF);
        rd(2'd2, v); chk("R2 ptr write masked", v, 32'h0000_03E0);

        // table-driven chains
        for (int vi = 0; vi < 6; vi++) begin
            vec_t tv;
            logic [31:0] exp_st;
            tv = VECS[vi];
            build(vi + 1, tv.n, tv.slot, tv.stride, tv.ie, tv.junk);
            wr(2'd2, ex_addr[0]);
            wr(2'd0, 32'h1);
            rd(2'd1, v); chk("R3 active flag", v & 32'h1, 32'h1);
            chk("R3 first read addr", mem_addr, ex_addr[0]);
            wait_idle();
            exp_st = {28'b0, tv.exp_eot, tv.exp_eoc, 1'b0} << 0;
            exp_st = {28'b0, 1'b0, tv.exp_eot, tv.exp_eoc, 1'b0};
            rd(2'd1, v); chk("R6 status events", v, exp_st);
            chk("R9 irq", {31'b0, irq}, {31'b0, tv.exp_eoc | tv.exp_eot});
            rd(2'd2, v); chk("R5 ptr zero at end", v, 0);
            rd(2'd0, v); chk("R5 ctrl zero at end", v, 0);
            chk("R4 descriptor count", 32'(log_n), 32'(tv.n));
            for (int i = 0; i < tv.n; i++) begin
                chk("R4 src0", log_s0[i], ex_s0[i]);
                chk("R3 src1", log_s1[i], ex_s1[i]);
                chk("R4 dst", log_dst[i], ex_dst[i]);
                chk("R4 len", log_len[i], ex_len[i]);
                chk("R4 ctrl", log_ctl[i], ex_ctl[i]);
            end
            rd(2'd1, v);
            wr(2'd1, v);
            rd(2'd1, v); chk("R8 clear by write-back", v, 0);
            chk("R9 irq low after clear", {31'b0, irq}, 0);
        end

        // R11 writes ignored while active
        resp_delay = 20;
        build(10, 2, 1, 12, 8'h00, 1'b0);
        wr(2'd2, ex_addr[0]);
        wr(2'd0, 32'h1);
        wait_valid();
        wr(2'd2, 32'h0000_07E0);
        rd(2'd2, v); chk("R11 ptr write ignored", v, ex_addr[1]);
        wr(2'd0, 32'h1);
        rd(2'd0, v); chk("R11 still active", v, 1);
        wait_idle();
        chk("R11 no restart", 32'(log_n), 2);

        // R10 stop mid-transfer
        build(11, 3, 5, 1, 8'h07, 1'b0);
        wr(2'd2, ex_addr[0]);
        wr(2'd0, 32'h1);
        wait_valid();
        wr(2'd0, 32'h0);
        chk("R10 valid dropped", {30'b0, xfer_valid, mem_req}, 0);
        rd(2'd0, v); chk("R10 inactive", v, 0);
        repeat (30) @(negedge clk);
        rd(2'd1, v); chk("R10 no event", v, 0);
        chk("R10 nothing done", 32'(log_n), 0);

        // R7 read fault after an event, then R8 partial clear
        resp_delay = 2;
        build(12, 3, 9, 1, 8'h01, 1'b0);
        err_fetch_on = 1'b1;
        err_addr = ex_addr[1] + 32'd8;
        wr(2'd2, ex_addr[0]);
        wr(2'd0, 32'h1);
        wait_idle();
        err_fetch_on = 1'b0;
        rd(2'd1, v); chk("R7 fetch fault status", v, 32'hC);
        chk("R7 one descriptor ran", 32'(log_n), 1);
        chk("R7 reads stopped", {31'b0, mem_req}, 0);
        wr(2'd1, 32'h4);
        rd(2'd1, v); chk("R8 partial clear", v, 32'h8);
        chk("R9 irq held by fault", {31'b0, irq}, 1);
        wr(2'd1, 32'h8);
        rd(2'd1, v); chk("R8 fault cleared", v, 0);

        // R7 datapath fault suppresses the event
        build(13, 2, 14, 1, 8'h03, 1'b0);
        err_xfer_at = 0;
        wr(2'd2, ex_addr[0]);
        wr(2'd0, 32'h1);
        wait_idle();
        err_xfer_at = -1;
        rd(2'd1, v); chk("R7 data fault status", v, 32'h8);
        chk("R7 chain halted", 32'(log_n), 1);
        rd(2'd0, v); chk("R7 ctrl cleared", v, 0);

        summary();
        $finish;
    end
endmodule